// File: doc/BRIEF.md
# Tile Diagnostic Test Pattern Generator

This block supplies the colour of each pixel of an LED tile while the tile runs one of its self-test displays. A raster walker outside the block presents an x/y coordinate with a request strobe. One clock later, the block returns a 24-bit RGB value with a valid strobe. A two-bit switch input picks the display.

The display choices are as follows. With both switches at 0, a white grid moves diagonally across the tile. With the switches at different values, a green text banner is drawn over that moving grid. With both switches at 1, every pixel shows a uniform dim grey, so an installer can spot dead or uneven LEDs.

A free-running prescaler steps the grid. On each step the lit column moves one pixel to the right and the lit row moves one pixel down. The font lookup is outside the block: it supplies one glyph bit for the pixel being requested.

Top module: `tile_pattern_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pix_valid` is 0 and `pix_rgb` is 0x000000 until the first request is served. The grid offset starts at 0.
- R2: `pix_valid` is high in exactly the cycle after a cycle in which `pix_req` was high. `pix_rgb` in that cycle is the colour for the coordinate presented with the request.
- R3: When `mode_sw` = 2'b00, a pixel is 0xFFFFFF if (x − off) mod 8 = 0 or (y − off) mod 8 = 0. Otherwise it is 0x000000. Here `off` is the grid offset in the cycle the request is taken.
- R4: The grid offset increases by 1, modulo 8, once every STEP_CYCLES clock cycles. The first increase comes STEP_CYCLES cycles after reset is released. The offset keeps advancing whatever the switch setting.
- R5: When `mode_sw` = 2'b11, every pixel is GREY_RGB (default 0x202020), whatever the coordinate and glyph bit.
- R6: When `mode_sw` is 2'b01 or 2'b10, a pixel whose y lies in [BANNER_TOP, BANNER_TOP+6) and whose `glyph_bit` is 1 is 0x00FF00. Every other pixel follows the grid rule of R3.
- R7: `glyph_bit` has no effect on the colour outside the banner rows, and no effect in modes 2'b00 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sw | input | 2 | Diagnostic switch pair (1 = up) |
| pix_req | input | 1 | Coordinate valid |
| pix_x | input | COORD_W | Pixel column |
| pix_y | input | COORD_W | Pixel row |
| glyph_bit | input | 1 | Font bit for the requested pixel |
| pix_valid | output | 1 | Colour valid, one cycle after request |
| pix_rgb | output | 24 | Colour, R in bits 23:16, B in bits 7:0 |

## Verification
A wrong grid offset or prescaler count moves every lit line in the grid and banner modes. The full-raster sweep therefore catches it within the first pixel row that follows the bad step. A wrong mode decode or banner window changes whole rows of colour the first time that mode is swept. A slip in the output register shows up on the very first request, as a valid strobe or colour that is one cycle off.

// File: rtl/tile_pattern_gen.sv
module tile_pattern_gen #(
  parameter int COORD_W     = 6,
  parameter int GRID_LOG2   = 3,
  parameter int STEP_CYCLES = 15_000_000,
  parameter int BANNER_TOP  = 8,
  parameter int BANNER_ROWS = 6,
  parameter logic [23:0] GREY_RGB = 24'h202020
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sw,
  input  logic               pix_req,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic               glyph_bit,
  output logic               pix_valid,
  output logic [23:0]        pix_rgb
);
  localparam int CNT_W = $clog2(STEP_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);
  localparam logic [COORD_W:0] BAN_LO = (COORD_W+1)'(BANNER_TOP);
  localparam logic [COORD_W:0] BAN_HI = (COORD_W+1)'(BANNER_TOP + BANNER_ROWS);
  localparam logic [23:0] WHITE = 24'hFFFFFF;
  localparam logic [23:0] GREEN = 24'h00FF00;

  logic [CNT_W-1:0]     step_cnt;
  logic [GRID_LOG2-1:0] grid_ofs;

  wire step_end = (step_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_cnt <= '0;
      grid_ofs <= '0;
    end else if (step_end) begin
      step_cnt <= '0;
      grid_ofs <= grid_ofs + 1'b1;
    end else begin
      step_cnt <= step_cnt + 1'b1;
    end
  end

  wire [GRID_LOG2-1:0] x_rel = pix_x[GRID_LOG2-1:0] - grid_ofs;
  wire [GRID_LOG2-1:0] y_rel = pix_y[GRID_LOG2-1:0] - grid_ofs;
  wire grid_on   = (x_rel == '0) || (y_rel == '0);
  wire in_banner = ({1'b0, pix_y} >= BAN_LO) && ({1'b0, pix_y} < BAN_HI);
  wire grey_mode = (mode_sw == 2'b11);
  wire text_mode = mode_sw[0] ^ mode_sw[1];

  logic [23:0] next_rgb;
  always_comb begin
    if (grey_mode)                           next_rgb = GREY_RGB;
    else if (text_mode && in_banner && glyph_bit) next_rgb = GREEN;
    else if (grid_on)                        next_rgb = WHITE;
    else                                     next_rgb = 24'h000000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_rgb   <= '0;
    end else begin
      pix_valid <= pix_req;
      if (pix_req) pix_rgb <= next_rgb;
    end
  end
endmodule

module tile_pattern_gen_chk #(
  parameter int CNT_W = 24,
  parameter int GRID_LOG2 = 3,
  parameter int STEP_CYCLES = 15_000_000,
  parameter logic [23:0] GREY_RGB = 24'h202020
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode_sw,
  input logic                 pix_req,
  input logic                 pix_valid,
  input logic [23:0]          pix_rgb,
  input logic [CNT_W-1:0]     step_cnt,
  input logic [GRID_LOG2-1:0] grid_ofs
);
  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |=> pix_valid);
  // R2
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> !pix_valid);
  // R4
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cnt != CNT_W'(STEP_CYCLES - 1)) |=> $stable(grid_ofs));
  // R4
  ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cnt == CNT_W'(STEP_CYCLES - 1)) |=> (grid_ofs == GRID_LOG2'($past(grid_ofs) + 1)));
  // R5
  grey_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && mode_sw == 2'b11) |=> (pix_rgb == GREY_RGB));
  // R3
  grid_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && mode_sw == 2'b00) |=> (pix_rgb == 24'hFFFFFF || pix_rgb == 24'h000000));
endmodule

bind tile_pattern_gen tile_pattern_gen_chk #(
  .CNT_W(CNT_W), .GRID_LOG2(GRID_LOG2), .STEP_CYCLES(STEP_CYCLES), .GREY_RGB(GREY_RGB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sw(mode_sw), .pix_req(pix_req),
  .pix_valid(pix_valid), .pix_rgb(pix_rgb), .step_cnt(step_cnt), .grid_ofs(grid_ofs)
);

// File: tb/tile_pattern_gen_bench.sv
module tile_pattern_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam int STEP = 20;
  localparam int BTOP = 8;
  localparam logic [23:0] GREY = 24'h202020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sw = 2'b00;
  logic pix_req = 1'b0;
  logic [CW-1:0] pix_x = '0, pix_y = '0;
  logic glyph_bit = 1'b0;
  logic pix_valid;
  logic [23:0] pix_rgb;

  int checks = 0, fails = 0;
  int mcnt, mofs;
  logic exp_v;
  logic [23:0] exp_rgb;
  string exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_pattern_gen #(.COORD_W(CW), .STEP_CYCLES(STEP), .BANNER_TOP(BTOP), .GREY_RGB(GREY))
    u_tile_pattern_gen (.clk(clk), .rst_n(rst_n), .mode_sw(mode_sw), .pix_req(pix_req),
      .pix_x(pix_x), .pix_y(pix_y), .glyph_bit(glyph_bit), .pix_valid(pix_valid), .pix_rgb(pix_rgb));

  function automatic logic [23:0] model(input logic [1:0] m, input int x, input int y,
                                        input logic g, input int o);
    if (m == 2'b11) return GREY;
    if ((m == 2'b01 || m == 2'b10) && y >= BTOP && y < BTOP + 6 && g) return 24'h00FF00;
    if (((x - o + 64) % 8) == 0 || ((y - o + 64) % 8) == 0) return 24'hFFFFFF;
    return 24'h000000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= 0; mofs <= 0; exp_v <= 1'b0; exp_rgb <= '0; exp_tag <= "R1";
    end else begin
      exp_v <= pix_req;
      if (pix_req) begin
        exp_rgb <= model(mode_sw, int'(pix_x), int'(pix_y), glyph_bit, mofs);
        if (mode_sw == 2'b11) exp_tag <= glyph_bit ? "R5 R7" : "R5";
        else if (mode_sw != 2'b00 && pix_y >= BTOP && pix_y < BTOP + 6) exp_tag <= "R6 R4";
        else exp_tag <= glyph_bit ? "R3 R4 R7" : "R3 R4";
      end
      if (mcnt == STEP - 1) begin mcnt <= 0; mofs <= (mofs + 1) % 8; end
      else mcnt <= mcnt + 1;
    end
  end

  task automatic check_out();
    checks++;
    if (pix_valid !== exp_v) begin
      fails++;
      $display("FAIL R2 valid actual=%0b expected=%0b", pix_valid, exp_v);
    end else if (exp_v && pix_rgb !== exp_rgb) begin
      fails++;
      $display("FAIL %s rgb actual=%06h expected=%06h", exp_tag, pix_rgb, exp_rgb);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pix_valid !== 1'b0 || pix_rgb !== 24'h0) begin
      fails++;
      $display("FAIL R1 reset actual=%0b/%06h expected=0/000000", pix_valid, pix_rgb);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_out();
    for (int m = 0; m < 4; m++) begin
      for (int y = 0; y < 64; y++) begin
        for (int x = 0; x < 64; x++) begin
          mode_sw = 2'(m);
          pix_x = 6'(x); pix_y = 6'(y);
          glyph_bit = ((x * 3 + y) % 5) == 0;
          pix_req = ((x + y + m) % 7) != 3;
          @(negedge clk);
          check_out();
        end
      end
    end
    pix_req = 1'b0;
    repeat (3) begin @(negedge clk); check_out(); end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule